// File: doc/BRIEF.md
# Interleaved Multiphase Buck PWM with Pulse Skipping and Load-Based Phase Shedding

This block produces the high-side and synchronous-rectifier gate pair for each phase of an interleaved buck converter. A single free-running period counter is divided into equal slots, one per phase. Each phase starts its switching period at the beginning of its own slot. At that moment it captures the shared duty command, the two rectifier dead-times and the minimum-duty setting. These values are then held for the rest of that phase's period. The upstream voltage loop can therefore present a fresh duty command once per slot.

The high-side switch conducts for the first `duty` cycles of a period. The rectifier conducts from `dt_off` cycles after the high-side turn-off until `dt_on` cycles before the next high-side turn-on. A large `dt_on` shortens the rectifier window, which emulates discontinuous conduction, and an empty window leaves the rectifier off. A duty command below the programmed minimum blanks both switches of that phase for the whole period, which produces pulse skipping at very light load.

A load-current scheduler compares the load-current code with programmable thresholds. It keeps one of three phase counts (all, half, single) and a rectifier enable. A common hysteresis offset must be exceeded before a phase count or the rectifier is restored.

Top module: `buck_mpwm`

## Requirements
- R1: With all phases live, phase k begins its high-side pulse k*SLOT cycles after phase 0, where SLOT = PERIOD/NPH, so consecutive phases are SLOT cycles apart.
- R2: When the captured duty d is at least the captured minimum, the high-side output of that phase is high for exactly d consecutive cycles at the start of its period.
- R3: When the captured duty is below the captured minimum, both outputs of that phase stay low for the entire period; a duty equal to the minimum is not skipped.
- R4: The rectifier output rises dt_off cycles after the high-side falls and falls dt_on cycles before the next high-side rise, so its pulse lasts PERIOD - d - dt_off - dt_on cycles.
- R5: When d + dt_off >= PERIOD - dt_on (for example a large dt_on for discontinuous conduction), the rectifier stays low for that period.
- R6: The high-side and rectifier outputs of a phase are never high in the same cycle.
- R7: Duty, dead-time, minimum and live/rectifier state are captured only at the start of a phase's period; a change in the middle of a period does not alter the pulse in progress.
- R8: A load code below th_sr disables the rectifier from the next period onward; it is enabled again only once the code reaches th_sr + hyst, and codes between the two keep the present state.
- R9: A load code below th_one leaves only phase 0 live; a code below th_two (but not below th_one) leaves phases 0 and NPH/2 live; a phase count rises to the next step only once the code reaches the matching threshold plus hyst.
- R10: A load code inside a hysteresis band [threshold, threshold + hyst) does not change the present phase count.
- R11: During reset all gate outputs are low; after reset all phases are live and the rectifier is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| duty_i | input | CW | Duty command in clock cycles, captured at each phase start |
| dt_on_i | input | CW | Gap from rectifier turn-off to the next high-side turn-on |
| dt_off_i | input | CW | Gap from high-side turn-off to rectifier turn-on |
| min_duty_i | input | CW | Minimum duty; smaller commands skip the pulse |
| iload_i | input | IW | Load-current code |
| th_sr_i | input | IW | Rectifier disable threshold |
| th_one_i | input | IW | Threshold below which a single phase runs |
| th_two_i | input | IW | Threshold below which half of the phases run |
| hyst_i | input | IW | Hysteresis offset added to each threshold when rising |
| hs_o | output | NPH | High-side gate per phase |
| ls_o | output | NPH | Rectifier gate per phase |

## Verification
The bench builds the block with four phases, a 40-cycle period and 8-bit load codes. With these values a slot is ten cycles, so a two-period observation window covers every phase several times in under a hundred cycles. Dead-times can be chosen to make the rectifier window exactly empty or only a few cycles long. All threshold and hysteresis band edges fit in the 8-bit load code, so each band edge can be driven on both sides.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    typedef enum logic [1:0] {
        MODE_ONE = 2'd0,
        MODE_TWO = 2'd1,
        MODE_ALL = 2'd2
    } mode_e;

    // Whether phase k runs under a given phase-count mode.
    function automatic logic phase_live(mode_e m, int k, int nph);
        logic r;
        case (m)
            MODE_ALL: r = 1'b1;
            MODE_TWO: r = (nph < 2) ? (k == 0) : ((k % (nph / 2)) == 0);
            default:  r = (k == 0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mpwm_slot_timer.sv
module mpwm_slot_timer #(
    parameter int NPH    = 4,
    parameter int PERIOD = 64,
    parameter int CW     = 7
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    output logic [NPH-1:0] start_o
);
    localparam int SLOT = PERIOD / NPH;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tmr_d.cnt = (tmr_q.cnt == CW'(PERIOD - 1)) ? '0 : tmr_q.cnt + CW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    for (genvar k = 0; k < NPH; k++) begin : g_start
        assign start_o[k] = (tmr_q.cnt == CW'(k * SLOT));
    end

    assert_slot_unique_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(start_o));

endmodule

// File: rtl/mpwm_load_sched.sv
module mpwm_load_sched
    import mpwm_pkg::*;
#(
    parameter int IW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [IW-1:0] iload_i,
    input  logic [IW-1:0] th_sr_i,
    input  logic [IW-1:0] th_one_i,
    input  logic [IW-1:0] th_two_i,
    input  logic [IW-1:0] hyst_i,
    output mode_e         mode_o,
    output logic          sr_en_o
);
    typedef struct packed {
        mode_e mode;
        logic  sr;
    } sch_t;

    sch_t sch_d, sch_q;
    logic [IW:0] up_one, up_two, up_sr, load_x;

    assign load_x = {1'b0, iload_i};
    assign up_one = {1'b0, th_one_i} + {1'b0, hyst_i};
    assign up_two = {1'b0, th_two_i} + {1'b0, hyst_i};
    assign up_sr  = {1'b0, th_sr_i}  + {1'b0, hyst_i};

    always_comb begin
        mode_e dn, up;
        sch_d = sch_q;
        if (iload_i < th_one_i)      dn = MODE_ONE;
        else if (iload_i < th_two_i) dn = MODE_TWO;
        else                         dn = MODE_ALL;
        if (load_x >= up_two)        up = MODE_ALL;
        else if (load_x >= up_one)   up = MODE_TWO;
        else                         up = MODE_ONE;
        if (sch_q.mode > dn)         sch_d.mode = dn;
        else if (sch_q.mode < up)    sch_d.mode = up;
        if (iload_i < th_sr_i)       sch_d.sr = 1'b0;
        else if (load_x >= up_sr)    sch_d.sr = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sch_q.mode <= MODE_ALL;
            sch_q.sr   <= 1'b1;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign mode_o  = sch_q.mode;
    assign sr_en_o = sch_q.sr;

    assert_shed_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iload_i < th_one_i && th_one_i <= th_two_i) |=> (mode_o == MODE_ONE));

    assert_rect_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iload_i < th_sr_i) |=> !sr_en_o);

    assert_band_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == MODE_ONE && iload_i >= th_one_i && load_x < up_one
         && th_one_i <= th_two_i) |=> (mode_o == MODE_ONE));

endmodule

// File: rtl/mpwm_phase_gate.sv
module mpwm_phase_gate #(
    parameter int PERIOD = 64,
    parameter int CW     = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          live_i,
    input  logic          sr_en_i,
    input  logic [CW-1:0] duty_i,
    input  logic [CW-1:0] dt_on_i,
    input  logic [CW-1:0] dt_off_i,
    input  logic [CW-1:0] min_i,
    output logic          hs_o,
    output logic          ls_o
);
    localparam int PW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] duty;
        logic [PW-1:0] beg;
        logic [PW-1:0] fin;
        logic          run;
        logic          sr;
        logic          hs;
        logic          ls;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        ph_d.cnt = (ph_q.cnt == CW'(PERIOD - 1)) ? '0 : ph_q.cnt + CW'(1);
        if (start_i) begin
            ph_d.cnt  = '0;
            ph_d.run  = live_i && (duty_i >= min_i);
            ph_d.sr   = sr_en_i;
            ph_d.duty = duty_i;
            ph_d.beg  = {1'b0, duty_i} + {1'b0, dt_off_i};
            ph_d.fin  = (dt_on_i >= CW'(PERIOD)) ? '0 : PW'(PERIOD) - {1'b0, dt_on_i};
        end
        // Gates are registered, decoded from the next-state fields.
        ph_d.hs = ph_d.run && (ph_d.cnt < ph_d.duty);
        ph_d.ls = ph_d.run && ph_d.sr
                  && ({1'b0, ph_d.cnt} >= ph_d.beg) && ({1'b0, ph_d.cnt} < ph_d.fin);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph_q     <= '0;
            ph_q.cnt <= CW'(PERIOD - 1);
        end else begin
            ph_q <= ph_d;
        end
    end

    assign hs_o = ph_q.hs;
    assign ls_o = ph_q.ls;

    assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hs_o && ls_o));

    assert_skip_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && duty_i < min_i) |=> (!hs_o && !ls_o));

    assert_rise_at_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_o) |-> $past(start_i));

endmodule

// File: rtl/buck_mpwm.sv
module buck_mpwm
    import mpwm_pkg::*;
#(
    parameter int  NPH    = 4,
    parameter int  PERIOD = 64,
    parameter int  IW     = 10,
    localparam int CW     = $clog2(PERIOD + 1)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [CW-1:0]  duty_i,
    input  logic [CW-1:0]  dt_on_i,
    input  logic [CW-1:0]  dt_off_i,
    input  logic [CW-1:0]  min_duty_i,
    input  logic [IW-1:0]  iload_i,
    input  logic [IW-1:0]  th_sr_i,
    input  logic [IW-1:0]  th_one_i,
    input  logic [IW-1:0]  th_two_i,
    input  logic [IW-1:0]  hyst_i,
    output logic [NPH-1:0] hs_o,
    output logic [NPH-1:0] ls_o
);
    logic [NPH-1:0] start;
    mode_e          mode;
    logic           sr_en;

    mpwm_slot_timer #(.NPH(NPH), .PERIOD(PERIOD), .CW(CW)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_o (start)
    );

    mpwm_load_sched #(.IW(IW)) u_sched (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .iload_i  (iload_i),
        .th_sr_i  (th_sr_i),
        .th_one_i (th_one_i),
        .th_two_i (th_two_i),
        .hyst_i   (hyst_i),
        .mode_o   (mode),
        .sr_en_o  (sr_en)
    );

    for (genvar k = 0; k < NPH; k++) begin : g_phase
        logic live;
        assign live = phase_live(mode, k, NPH);

        mpwm_phase_gate #(.PERIOD(PERIOD), .CW(CW)) u_gate (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .start_i  (start[k]),
            .live_i   (live),
            .sr_en_i  (sr_en),
            .duty_i   (duty_i),
            .dt_on_i  (dt_on_i),
            .dt_off_i (dt_off_i),
            .min_i    (min_duty_i),
            .hs_o     (hs_o[k]),
            .ls_o     (ls_o[k])
        );
    end

endmodule

// File: tb/sim_buck_mpwm.sv
`timescale 1ns/1ps
module sim_buck_mpwm;
    localparam int NP   = 4;
    localparam int PER  = 40;
    localparam int SLOT = PER / NP;
    localparam int IW   = 8;
    localparam int CW   = $clog2(PER + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] duty, dt_on, dt_off, mind;
    logic [IW-1:0] iload, th_sr, th_one, th_two, hyst;
    logic [NP-1:0] hs, ls;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int hcnt [NP];
    int lcnt [NP];
    int ovl;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    buck_mpwm #(.NPH(NP), .PERIOD(PER), .IW(IW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .dt_on_i(dt_on), .dt_off_i(dt_off),
        .min_duty_i(mind), .iload_i(iload), .th_sr_i(th_sr), .th_one_i(th_one),
        .th_two_i(th_two), .hyst_i(hyst), .hs_o(hs), .ls_o(ls)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(input int p, output bit found);
        bit prev;
        found = 1'b0;
        prev = hs[p];
        for (int i = 0; i < 4 * PER; i++) begin
            @(negedge clk);
            if (!prev && hs[p]) begin
                found = 1'b1;
                return;
            end
            prev = hs[p];
        end
    endtask

    task automatic window(input int ncyc);
        for (int k = 0; k < NP; k++) begin hcnt[k] = 0; lcnt[k] = 0; end
        ovl = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            for (int k = 0; k < NP; k++) begin
                if (hs[k]) hcnt[k]++;
                if (ls[k]) lcnt[k]++;
                if (hs[k] && ls[k]) ovl++;
            end
        end
    endtask

    task automatic settle();
        repeat (2 * PER + 2) @(negedge clk);
    endtask

    task automatic shape(input int p, input string req, input int eh, input int eg1,
                         input int el, input int eg2);
        int hi = 0, g1 = 0, l = 0, g2 = 0;
        bit f;
        wait_rise(p, f);
        chk(f, req, 0, 1);
        while (hs[p] && hi < 2 * PER) begin hi++; @(negedge clk); end
        while (!hs[p] && !ls[p] && g1 < 2 * PER) begin g1++; @(negedge clk); end
        while (ls[p] && l < 2 * PER) begin l++; @(negedge clk); end
        while (!hs[p] && !ls[p] && g2 < 2 * PER) begin g2++; @(negedge clk); end
        chk(hi == eh, {req, " high-side width"}, hi, eh);
        chk(g1 == eg1, {req, " turn-off gap"}, g1, eg1);
        chk(l == el, {req, " rectifier width"}, l, el);
        chk(g2 == eg2, {req, " turn-on gap"}, g2, eg2);
    endtask

    // Phase set given as mask; duty 12, dt_off 3, dt_on 2 assumed.
    task automatic live_check(input string req, input logic [NP-1:0] mask, input bit sr);
        settle();
        window(2 * PER);
        for (int k = 0; k < NP; k++) begin
            chk(hcnt[k] == (mask[k] ? 24 : 0), {req, " high-side count"}, hcnt[k], mask[k] ? 24 : 0);
            chk(lcnt[k] == ((mask[k] && sr) ? 46 : 0), {req, " rectifier count"}, lcnt[k],
                (mask[k] && sr) ? 46 : 0);
        end
        chk(ovl == 0, "R6 overlap", ovl, 0);
    endtask

    task automatic t_reset();
        duty = 12; dt_off = 3; dt_on = 2; mind = 2;
        iload = 100; th_sr = 10; th_one = 20; th_two = 50; hyst = 8;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(hs == '0, "R11 high-side in reset", int'(hs), 0);
        chk(ls == '0, "R11 rectifier in reset", int'(ls), 0);
        rst_n = 1'b1;
        live_check("R11 after reset", 4'b1111, 1'b1);
    endtask

    task automatic t_shape();
        shape(2, "R2 R4 base", 12, 3, 23, 2);
        duty = 20; dt_off = 1; dt_on = 5;
        settle();
        shape(1, "R2 R4 wide", 20, 1, 14, 5);
        duty = 12; dt_off = 3; dt_on = 2;
        settle();
    endtask

    task automatic t_interleave();
        bit f;
        int t0, t1;
        wait_rise(0, f);
        t0 = cyc;
        for (int k = 1; k <= NP; k++) begin
            wait_rise(k % NP, f);
            t1 = cyc;
            chk(f && (t1 - t0 == SLOT), "R1 interleave spacing", t1 - t0, SLOT);
            t0 = t1;
        end
    endtask

    task automatic t_skip();
        duty = 1;
        settle();
        window(2 * PER);
        for (int k = 0; k < NP; k++)
            chk(hcnt[k] == 0 && lcnt[k] == 0, "R3 skipped period", hcnt[k] + lcnt[k], 0);
        duty = 2;
        settle();
        window(2 * PER);
        chk(hcnt[3] == 4, "R3 duty at minimum high-side", hcnt[3], 4);
        chk(lcnt[3] == 66, "R3 duty at minimum rectifier", lcnt[3], 66);
        duty = 12;
        settle();
    endtask

    task automatic t_dcm();
        dt_on = 25;
        settle();
        window(2 * PER);
        chk(lcnt[0] == 0, "R5 empty rectifier window", lcnt[0], 0);
        chk(hcnt[0] == 24, "R5 high-side kept", hcnt[0], 24);
        dt_on = 20;
        settle();
        shape(0, "R5 short dcm window", 12, 3, 5, 20);
        dt_on = 2;
        settle();
    endtask

    task automatic t_latch();
        bit f;
        int hi = 0;
        wait_rise(0, f);
        duty = 30; dt_off = 0;
        while (hs[0] && hi < 2 * PER) begin hi++; @(negedge clk); end
        chk(hi == 12, "R7 mid-period change ignored", hi, 12);
        duty = 12; dt_off = 3;
        settle();
    endtask

    task automatic t_sched();
        iload = 45;  live_check("R9 half phases", 4'b0101, 1'b1);
        iload = 52;  live_check("R10 upper band holds", 4'b0101, 1'b1);
        iload = 60;  live_check("R9 all phases restored", 4'b1111, 1'b1);
        iload = 15;  live_check("R9 single phase", 4'b0001, 1'b1);
        iload = 25;  live_check("R10 lower band holds", 4'b0001, 1'b1);
        iload = 5;   live_check("R8 rectifier off", 4'b0001, 1'b0);
        iload = 14;  live_check("R8 rectifier band holds", 4'b0001, 1'b0);
        iload = 20;  live_check("R8 rectifier restored", 4'b0001, 1'b1);
        iload = 30;  live_check("R9 rise to half", 4'b0101, 1'b1);
    endtask

    initial begin
        t_reset();
        t_shape();
        t_interleave();
        t_skip();
        t_dcm();
        t_latch();
        t_sched();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule